// File: doc/BRIEF.md
# Modem Control and Status Register Pair

This block holds the modem-control and modem-status registers of a 16550-style serial port. The control register drives four handshake outputs: request-to-send, terminal-ready and two general-purpose outputs. It also holds a loopback switch. The status register tracks four modem inputs: clear-to-send, data-set-ready, ring and carrier detect. Each input passes through a synchroniser before it is compared with the stored copy. Any change latches a sticky delta flag. The flags stay set until software reads the status register.

Both registers share one byte-wide register port. `reg_sel` picks the control register (0) or the status register (1). The read data is combinational. A status read, qualified by `rd_en`, clears the delta flags after the value has been returned. In loopback the status read shows the control bits rather than the inputs, and the terminal-ready and request-to-send pins are forced low. The OR of the delta flags leaves the block on `delta_any` for the interrupt logic.

Top module: `modem_ctl_stat`

## Requirements
- R1: After reset, the status register reads 0xB0 (carrier, data-set-ready and clear-to-send set, no deltas). The control register reads 0x08. `delta_any` is 0. Pins: `rts_out`=0, `dtr_out`=0, `out1_out`=0, `out2_out`=1.
- R2: A control write keeps data bits 4:0: bit0 terminal-ready, bit1 request-to-send, bit2 general output 1, bit3 general output 2, bit4 loopback. A control read returns those five bits with bits 7:5 as zero.
- R3: Outside loopback, `dtr_out`, `rts_out`, `out1_out` and `out2_out` equal control bits 0, 1, 2 and 3 respectively.
- R4: Status byte layout: bit4 clear-to-send, bit5 data-set-ready, bit6 ring, bit7 carrier. A change on an input pin shows in these bits after exactly three rising clock edges (two synchroniser stages plus the register). Before the third edge the old value is still read.
- R5: Any change of clear-to-send, data-set-ready or carrier, in either direction, sets its delta flag. The flags are bit0, bit1 and bit3 respectively.
- R6: The ring delta flag (bit2) is set only when the registered ring state falls from 1 to 0. A rise sets nothing.
- R7: Delta flags accumulate. Once set, a flag stays set until a status read clears it.
- R8: A status read with `rd_en` returns the current byte, and at that clock edge clears all four delta flags. A change detected on the same edge still sets its flag.
- R9: `delta_any` is 1 exactly when at least one delta flag is set.
- R10: In loopback a status read returns bit7=general output 2, bit6=general output 1, bit5=terminal-ready and bit4=request-to-send, with bits 3:0 as zero.
- R11: In loopback `rts_out` and `dtr_out` are 0. `out1_out` and `out2_out` still follow their control bits.
- R12: In loopback the stored status and delta flags are frozen. Input changes and status reads do not alter them. After loopback ends, a difference between the inputs and the stored status registers as an ordinary change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_sel | input | 1 | 0 selects control register, 1 selects status register |
| wr_en | input | 1 | Write strobe (control register only) |
| rd_en | input | 1 | Read strobe; on status, clears the delta flags |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Combinational read data of the selected register |
| cts_in | input | 1 | Clear-to-send input, active high |
| dsr_in | input | 1 | Data-set-ready input, active high |
| ri_in | input | 1 | Ring input, active high |
| dcd_in | input | 1 | Carrier-detect input, active high |
| rts_out | output | 1 | Request-to-send output |
| dtr_out | output | 1 | Terminal-ready output |
| out1_out | output | 1 | General output 1 |
| out2_out | output | 1 | General output 2 |
| delta_any | output | 1 | OR of the four delta flags |

## Verification
The assertions assume the modem inputs are held at their reset-time levels while reset is asserted. The synchroniser flops reset to the status reset pattern, so matching inputs produce no spurious flag after reset. The assertions also take `rd_en` as a single-cycle strobe, so a read clears the flags once and the stickiness check sees a clean edge.

The bench changes inputs only at falling edges and holds each level for at least four cycles. Every change therefore passes whole through the synchroniser before the next change arrives. The bench samples read data a short delay after setting `reg_sel`, and never in the same half-cycle as a clock edge.

// File: rtl/modem_pkg.sv
package modem_pkg;

  localparam int CTRL_W = 5;
  localparam int LINE_W = 4;

  // control register bit positions
  localparam int MC_DTR  = 0;
  localparam int MC_RTS  = 1;
  localparam int MC_OUT1 = 2;
  localparam int MC_OUT2 = 3;
  localparam int MC_LOOP = 4;

  // line nibble bit positions (status byte bits 7:4, delta bits 3:0)
  localparam int LN_CTS = 0;
  localparam int LN_DSR = 1;
  localparam int LN_RI  = 2;
  localparam int LN_DCD = 3;

  localparam logic [LINE_W-1:0] LINE_RESET = 4'b1011;
  localparam logic [CTRL_W-1:0] CTRL_RESET = 5'b01000;

  typedef enum logic {SEL_CTRL = 1'b0, SEL_STAT = 1'b1} reg_sel_e;

  // change flags between a stored and a newly sampled line nibble;
  // ring only counts its falling edge
  function automatic logic [LINE_W-1:0] line_delta(input logic [LINE_W-1:0] prev,
                                                   input logic [LINE_W-1:0] curr);
    logic [LINE_W-1:0] d;
    d = prev ^ curr;
    d[LN_RI] = prev[LN_RI] & ~curr[LN_RI];
    return d;
  endfunction

  // status nibble seen in loopback, built from the control bits
  function automatic logic [LINE_W-1:0] loop_lines(input logic [CTRL_W-1:0] ctrl);
    logic [LINE_W-1:0] s;
    s[LN_CTS] = ctrl[MC_RTS];
    s[LN_DSR] = ctrl[MC_DTR];
    s[LN_RI]  = ctrl[MC_OUT1];
    s[LN_DCD] = ctrl[MC_OUT2];
    return s;
  endfunction

endpackage

// File: rtl/modem_sync.sv
module modem_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] q_sync
);
  logic [W-1:0] stage_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[s] <= RST_VAL;
          else        stage_q[s] <= d_async;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[s] <= RST_VAL;
          else        stage_q[s] <= stage_q[s-1];
        end
      end
    end
  endgenerate

  assign q_sync = stage_q[STAGES-1];
endmodule

// File: rtl/modem_ctrl_reg.sv
module modem_ctrl_reg
  import modem_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [CTRL_W-1:0] wr_bits,
  output logic [CTRL_W-1:0] ctrl_q,
  output logic              loop_on,
  output logic              rts_pin,
  output logic              dtr_pin,
  output logic              out1_pin,
  output logic              out2_pin
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ctrl_q <= CTRL_RESET;
    else if (wr_en) ctrl_q <= wr_bits;
  end

  assign loop_on  = ctrl_q[MC_LOOP];
  assign rts_pin  = ctrl_q[MC_RTS] & ~loop_on;
  assign dtr_pin  = ctrl_q[MC_DTR] & ~loop_on;
  assign out1_pin = ctrl_q[MC_OUT1];
  assign out2_pin = ctrl_q[MC_OUT2];

  AST_LOOP_PINS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    loop_on |-> (!rts_pin && !dtr_pin)); // R11

  AST_CTRL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(ctrl_q)); // R2
endmodule

// File: rtl/modem_status_reg.sv
module modem_status_reg
  import modem_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sample_en,
  input  logic              clr_req,
  input  logic [LINE_W-1:0] line_now,
  output logic [LINE_W-1:0] line_q,
  output logic [LINE_W-1:0] delta_q
);
  logic [LINE_W-1:0] chg_vec;
  logic              clr_ev;
  logic              chg_any;

  assign chg_vec = sample_en ? line_delta(line_q, line_now) : '0;
  assign clr_ev  = clr_req & sample_en;
  assign chg_any = |chg_vec;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_q  <= LINE_RESET;
      delta_q <= '0;
    end else begin
      if (sample_en) line_q <= line_now;
      delta_q <= (clr_ev ? '0 : delta_q) | chg_vec;
    end
  end

  AST_TERI_FALL_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(delta_q[LN_RI]) |-> ($past(line_q[LN_RI]) && !line_q[LN_RI])); // R6

  AST_EDGE_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (((line_q ^ $past(line_q)) & 4'b1011) != 4'b0000) |->
      ((delta_q & (line_q ^ $past(line_q)) & 4'b1011) == ((line_q ^ $past(line_q)) & 4'b1011))); // R5

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_ev |=> ((delta_q & $past(delta_q)) == $past(delta_q))); // R7

  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_ev && !chg_any) |=> (delta_q == 4'b0000)); // R8

  AST_LOOP_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_en |=> ($stable(line_q) && $stable(delta_q))); // R12
endmodule

// File: rtl/modem_ctl_stat.sv
module modem_ctl_stat
  import modem_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int DATA_W      = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_sel,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  input  logic              cts_in,
  input  logic              dsr_in,
  input  logic              ri_in,
  input  logic              dcd_in,
  output logic              rts_out,
  output logic              dtr_out,
  output logic              out1_out,
  output logic              out2_out,
  output logic              delta_any
);
  localparam int PAD_W = DATA_W - CTRL_W;

  logic [LINE_W-1:0] line_raw;
  logic [LINE_W-1:0] line_sync;
  logic [LINE_W-1:0] line_q;
  logic [LINE_W-1:0] delta_q;
  logic [CTRL_W-1:0] ctrl_q;
  logic              loop_on;
  logic              ctrl_wr;
  logic              stat_rd;
  logic [DATA_W-1:0] stat_byte;

  always_comb begin
    line_raw         = '0;
    line_raw[LN_CTS] = cts_in;
    line_raw[LN_DSR] = dsr_in;
    line_raw[LN_RI]  = ri_in;
    line_raw[LN_DCD] = dcd_in;
  end

  modem_sync #(.W(LINE_W), .STAGES(SYNC_STAGES), .RST_VAL(LINE_RESET)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_async (line_raw),
    .q_sync  (line_sync)
  );

  assign ctrl_wr = wr_en & (reg_sel == SEL_CTRL);
  assign stat_rd = rd_en & (reg_sel == SEL_STAT);

  modem_ctrl_reg u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (ctrl_wr),
    .wr_bits  (wr_data[CTRL_W-1:0]),
    .ctrl_q   (ctrl_q),
    .loop_on  (loop_on),
    .rts_pin  (rts_out),
    .dtr_pin  (dtr_out),
    .out1_pin (out1_out),
    .out2_pin (out2_out)
  );

  modem_status_reg u_stat (
    .clk       (clk),
    .rst_n     (rst_n),
    .sample_en (~loop_on),
    .clr_req   (stat_rd),
    .line_now  (line_sync),
    .line_q    (line_q),
    .delta_q   (delta_q)
  );

  always_comb begin
    if (loop_on) stat_byte = {loop_lines(ctrl_q), {LINE_W{1'b0}}};
    else         stat_byte = {line_q, delta_q};
  end

  assign rd_data   = (reg_sel == SEL_STAT) ? stat_byte : {{PAD_W{1'b0}}, ctrl_q};
  assign delta_any = |delta_q;

  AST_DELTA_FLAG_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    (delta_any && !stat_rd && !wr_en) |=> delta_any); // R9
endmodule

// File: tb/sim_modem_ctl_stat.sv
module sim_modem_ctl_stat;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_sel = 1'b0;
  logic       wr_en = 1'b0;
  logic       rd_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic       cts_in = 1'b1, dsr_in = 1'b1, ri_in = 1'b0, dcd_in = 1'b1;
  logic       rts_out, dtr_out, out1_out, out2_out, delta_any;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  modem_ctl_stat u0 (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .wr_en(wr_en), .rd_en(rd_en),
    .wr_data(wr_data), .rd_data(rd_data),
    .cts_in(cts_in), .dsr_in(dsr_in), .ri_in(ri_in), .dcd_in(dcd_in),
    .rts_out(rts_out), .dtr_out(dtr_out), .out1_out(out1_out), .out2_out(out2_out),
    .delta_any(delta_any)
  );

  typedef struct packed {
    logic [7:0] wval;
    logic [7:0] ctrl_exp;
    logic [3:0] pins_exp;   // {rts, dtr, out1, out2}
    logic       msr_chk;
    logic [7:0] msr_exp;
  } vec_t;

  localparam int NVEC = 7;
  localparam vec_t TBL [NVEC] = '{
    '{wval:8'h00, ctrl_exp:8'h00, pins_exp:4'b0000, msr_chk:1'b0, msr_exp:8'h00},
    '{wval:8'h03, ctrl_exp:8'h03, pins_exp:4'b1100, msr_chk:1'b0, msr_exp:8'h00},
    '{wval:8'hFF, ctrl_exp:8'h1F, pins_exp:4'b0011, msr_chk:1'b1, msr_exp:8'hF0},
    '{wval:8'h0F, ctrl_exp:8'h0F, pins_exp:4'b1111, msr_chk:1'b0, msr_exp:8'h00},
    '{wval:8'hE4, ctrl_exp:8'h04, pins_exp:4'b0010, msr_chk:1'b0, msr_exp:8'h00},
    '{wval:8'h11, ctrl_exp:8'h11, pins_exp:4'b0000, msr_chk:1'b1, msr_exp:8'h20},
    '{wval:8'h08, ctrl_exp:8'h08, pins_exp:4'b0001, msr_chk:1'b0, msr_exp:8'h00}
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%02h expected=0x%02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic s, input logic [7:0] d);
    @(negedge clk);
    reg_sel = s; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic peek(input logic s, output logic [7:0] v);
    reg_sel = s;
    #1;
    v = rd_data;
  endtask

  task automatic rd(input logic s, output logic [7:0] v);
    reg_sel = s; rd_en = 1'b1;
    #1;
    v = rd_data;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin : main
    logic [7:0] v;
    wait_cyc(3);
    rst_n = 1'b1;
    wait_cyc(2);

    // R1 reset state
    peek(1'b1, v); chk("R1 status reset", v, 8'hB0);
    peek(1'b0, v); chk("R1 control reset", v, 8'h08);
    chk("R1 delta_any reset", {7'b0, delta_any}, 8'h00);
    chk("R1 pins reset", {4'b0, rts_out, dtr_out, out1_out, out2_out}, 8'h01);

    // R2 R3 R10 R11 table walk of control writes
    for (int i = 0; i < NVEC; i++) begin
      wr(1'b0, TBL[i].wval);
      peek(1'b0, v); chk("R2 control readback", v, TBL[i].ctrl_exp);
      chk("R3/R11 pins", {4'b0, rts_out, dtr_out, out1_out, out2_out}, {4'b0, TBL[i].pins_exp});
      if (TBL[i].msr_chk) begin
        rd(1'b1, v); chk("R10 loopback status", v, TBL[i].msr_exp);
      end
    end

    // R4 latency of three edges, R5 clear-to-send edge
    cts_in = 1'b0;
    wait_cyc(2);
    peek(1'b1, v); chk("R4 not yet visible", v, 8'hB0);
    wait_cyc(1);
    peek(1'b1, v); chk("R4 visible at third edge", v, 8'hA1);
    chk("R9 delta_any set", {7'b0, delta_any}, 8'h01);
    rd(1'b1, v); chk("R8 read returns value", v, 8'hA1);
    peek(1'b1, v); chk("R8 flags cleared", v, 8'hA0);
    chk("R9 delta_any clear", {7'b0, delta_any}, 8'h00);

    // R5 falling DSR and DCD, then R7 accumulation with rising CTS
    dsr_in = 1'b0; dcd_in = 1'b0;
    wait_cyc(4);
    peek(1'b1, v); chk("R5 dsr/dcd flags", v, 8'h0A);
    cts_in = 1'b1;
    wait_cyc(4);
    peek(1'b1, v); chk("R7 flags accumulate", v, 8'h1B);
    rd(1'b1, v); chk("R7 read accumulated", v, 8'h1B);
    peek(1'b1, v); chk("R8 cleared after read", v, 8'h10);

    // R6 ring: rise sets nothing, fall sets bit2
    ri_in = 1'b1;
    wait_cyc(4);
    peek(1'b1, v); chk("R6 ring rise no flag", v, 8'h50);
    chk("R6 delta_any after rise", {7'b0, delta_any}, 8'h00);
    ri_in = 1'b0;
    wait_cyc(4);
    peek(1'b1, v); chk("R6 ring fall flag", v, 8'h14);
    rd(1'b1, v);
    peek(1'b1, v); chk("R8 ring flag cleared", v, 8'h10);

    // R12 loopback freezes stored status and flags
    cts_in = 1'b0;
    wait_cyc(4);
    peek(1'b1, v); chk("R5 cts fall", v, 8'h01);
    wr(1'b0, 8'h10);
    chk("R11 loop pins", {4'b0, rts_out, dtr_out, out1_out, out2_out}, 8'h00);
    dcd_in = 1'b1;
    wait_cyc(4);
    rd(1'b1, v); chk("R10 loop read all low", v, 8'h00);
    chk("R12 flags kept in loop", {7'b0, delta_any}, 8'h01);
    wr(1'b0, 8'h00);
    wait_cyc(4);
    peek(1'b1, v); chk("R12 catch-up after loop", v, 8'h89);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule